// File: doc/BRIEF.md
# Display Memory Shadow for a Snooped Host Bus

This block listens without driving anything on an 8-bit host bus with a phase-2 clock. When the host writes into one of its four display areas (two text/low-res pages and two high-res pages), the block keeps a copy of that byte in an internal 18 KB shadow store. A video engine can then read that store through its own port instead of fetching host memory. The block also follows the eight soft-switch addresses that choose graphics or text, mixed or full screen, page 1 or page 2, and low-res or high-res. It presents the result as four mode flags.

The bus pins are sampled in a faster local clock domain. A two-flop synchroniser follows the phase-2 clock, and a falling edge on it latches the address, data and read/write level. A four-state capture machine handles each bus cycle in turn. IDLE waits for the edge and latches the bus. DECODE classifies the latched address. WRITE commits one byte to the shadow store. SWITCH updates a mode flag. The transitions are: IDLE to DECODE on a detected fall; DECODE to WRITE for a write into a display area; DECODE to SWITCH for any access to a soft switch; DECODE to IDLE for anything else; WRITE and SWITCH always return to IDLE. The store is split into byte-wide banks. The read port is registered and independent of the capture side.

Top module: `vsh_video_shadow`

## Requirements
- R1: A host write to 0x0400–0x07FF stores its data at shadow index (address − 0x0400), the range 0x0000–0x03FF.
- R2: A host write to 0x0800–0x0BFF stores its data at shadow index 0x0400 + (address − 0x0800).
- R3: A host write to 0x2000–0x3FFF stores its data at shadow index 0x0800 + (address − 0x2000).
- R4: A host write to 0x4000–0x5FFF stores its data at shadow index 0x2800 + (address − 0x4000), so the last host byte 0x5FFF lands at 0x47FF.
- R5: A bus cycle with bus_rnw high (read) into a display area leaves the shadow store unchanged. Only bus_rnw low commits a byte.
- R6: A host access to any address outside the four display areas and 0xC050–0xC057 changes neither the shadow store nor the mode flags.
- R7: An access to 0xC050 sets mode_graphics to 1. An access to 0xC051 clears it.
- R8: An access to 0xC052 sets mode_mixed to 1. An access to 0xC053 clears it.
- R9: An access to 0xC055 sets mode_page2 to 1. An access to 0xC054 clears it.
- R10: An access to 0xC057 sets mode_hires to 1. An access to 0xC056 clears it.
- R11: A soft switch acts on a read access as well as on a write, and the data value has no effect. No mode flag changes except through a switch access.
- R12: After reset, all four mode flags are 0 (text, full screen, page 1, low-res).
- R13: The machine is back in IDLE within four local cycles of each detected phase-2 fall. Back-to-back bus cycles with a period of ten local cycles therefore all get committed.
- R14: rd_data shows the byte at rd_addr one clock after rd_addr is presented. If a capture write hits the same index, rd_data shows only the old byte or the new byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_phi2 | input | 1 | Host phase-2 clock, asynchronous to clk |
| bus_addr | input | 16 | Host address |
| bus_data | input | 8 | Host data |
| bus_rnw | input | 1 | 1 = host read, 0 = host write |
| rd_addr | input | 15 | Shadow index for the scan-out read port |
| rd_data | output | 8 | Shadow byte, one cycle after rd_addr |
| mode_graphics | output | 1 | 1 = graphics, 0 = text |
| mode_mixed | output | 1 | 1 = mixed, 0 = full screen |
| mode_page2 | output | 1 | 1 = page 2, 0 = page 1 |
| mode_hires | output | 1 | 1 = high-res, 0 = low-res |

## Verification
The bench builds the block with its default parameters: 10 text address bits, 13 high-res address bits and four byte banks. This gives the full 18 KB map, so the first and last host byte of each of the four pages, and the very last shadow index 0x47FF, can be reached directly. With four banks, a run of consecutive addresses passes through every bank position, and a fast burst of writes then tests the read mux and the bank write enables as well as the rate limit. The collision case keeps the read port on an index while the host overwrites it, and checks every cycle that only the old or the new byte appears.

// File: rtl/vshadow_pkg.sv
package vshadow_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECODE,
        ST_WRITE,
        ST_SWITCH
    } cap_state_e;

    typedef struct packed {
        logic graphics;
        logic mixed;
        logic page2;
        logic hires;
    } vmode_t;

    localparam logic [15:0] HOST_TXT_BASE = 16'h0400;
    localparam logic [15:0] HOST_HGR_BASE = 16'h2000;
    localparam logic [15:0] HOST_SW_BASE  = 16'hC050;

    localparam vmode_t MODE_RESET = '{graphics: 1'b0, mixed: 1'b0, page2: 1'b0, hires: 1'b0};

endpackage

// File: rtl/vsh_edge_sync.sv
module vsh_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic fall
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= async_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign fall = s3_q & ~s2_q;
endmodule

// File: rtl/vsh_decode.sv
module vsh_decode
    import vshadow_pkg::*;
#(
    parameter int TXT_AW = 10,
    parameter int HGR_AW = 13,
    parameter int SAW    = 15
) (
    input  logic [15:0]    addr,
    output logic           shadow_hit,
    output logic [SAW-1:0] shadow_idx,
    output logic           switch_hit,
    output logic [1:0]     switch_sel,
    output logic           switch_val
);
    localparam int TXT_SPAN = 2 << TXT_AW;
    localparam int HGR_SPAN = 2 << HGR_AW;

    logic [16:0] txt_off, hgr_off;
    logic        txt_in, hgr_in;

    assign txt_off = {1'b0, addr} - {1'b0, HOST_TXT_BASE};
    assign hgr_off = {1'b0, addr} - {1'b0, HOST_HGR_BASE};
    assign txt_in  = txt_off < 17'(TXT_SPAN);
    assign hgr_in  = hgr_off < 17'(HGR_SPAN);

    always_comb begin
        shadow_idx = '0;
        if (txt_in) begin
            shadow_idx = SAW'(txt_off);
        end else if (hgr_in) begin
            shadow_idx = SAW'(hgr_off + 17'(TXT_SPAN));
        end
    end

    assign shadow_hit = txt_in | hgr_in;
    assign switch_hit = (addr[15:3] == HOST_SW_BASE[15:3]);
    assign switch_sel = addr[2:1];
    // graphics and mixed are set by the even address; page2 and hires by the odd one
    assign switch_val = addr[2] ? addr[0] : ~addr[0];
endmodule

// File: rtl/vsh_capture_fsm.sv
module vsh_capture_fsm
    import vshadow_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fall,
    input  logic [15:0] bus_addr,
    input  logic [7:0]  bus_data,
    input  logic        bus_rnw,
    input  logic        shadow_hit,
    input  logic        switch_hit,
    output logic [15:0] lat_addr,
    output logic [7:0]  lat_data,
    output cap_state_e  state,
    output logic        wr_en,
    output logic        sw_en
);
    cap_state_e state_q, state_d;
    logic       lat_rnw;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (fall) state_d = ST_DECODE;
            ST_DECODE: begin
                if (shadow_hit && !lat_rnw) begin
                    state_d = ST_WRITE;
                end else if (switch_hit) begin
                    state_d = ST_SWITCH;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_WRITE:  state_d = ST_IDLE;
            ST_SWITCH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        wr_en = 1'b0;
        sw_en = 1'b0;
        unique case (state_q)
            ST_WRITE:  wr_en = 1'b1;
            ST_SWITCH: sw_en = 1'b1;
            default: begin
                wr_en = 1'b0;
                sw_en = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_addr <= '0;
            lat_data <= '0;
            lat_rnw  <= 1'b1;
        end else if (state_q == ST_IDLE && fall) begin
            lat_addr <= bus_addr;
            lat_data <= bus_data;
            lat_rnw  <= bus_rnw;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/vsh_shadow_mem.sv
module vsh_shadow_mem #(
    parameter int DEPTH = 18432,
    parameter int LANES = 4,
    parameter int SAW   = 15
) (
    input  logic           clk,
    input  logic           wr_en,
    input  logic [SAW-1:0] wr_idx,
    input  logic [7:0]     wr_data,
    input  logic [SAW-1:0] rd_idx,
    output logic [7:0]     rd_data
);
    localparam int LANE_W = $clog2(LANES);
    localparam int WORDS  = DEPTH / LANES;
    localparam int WAW    = SAW - LANE_W;

    logic [WAW-1:0]      wr_word, rd_word;
    logic [LANE_W-1:0]   wr_lane, rd_lane, rd_lane_q;
    logic [LANES*8-1:0]  rd_row;

    assign wr_word = wr_idx[SAW-1:LANE_W];
    assign wr_lane = wr_idx[LANE_W-1:0];
    assign rd_word = rd_idx[SAW-1:LANE_W];
    assign rd_lane = rd_idx[LANE_W-1:0];

    for (genvar g = 0; g < LANES; g++) begin : g_bank
        logic [7:0] bank [WORDS];
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (wr_en && wr_lane == LANE_W'(g)) begin
                bank[wr_word] <= wr_data;
            end
            q <= bank[rd_word];
        end
        assign rd_row[g*8 +: 8] = q;
    end

    always_ff @(posedge clk) begin
        rd_lane_q <= rd_lane;
    end

    assign rd_data = rd_row[rd_lane_q*8 +: 8];
endmodule

// File: rtl/vsh_video_shadow.sv
module vsh_video_shadow
    import vshadow_pkg::*;
#(
    parameter int TXT_AW   = 10,
    parameter int HGR_AW   = 13,
    parameter int LANES    = 4,
    localparam int DEPTH   = 2 * ((1 << TXT_AW) + (1 << HGR_AW)),
    localparam int SAW     = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_phi2,
    input  logic [15:0]    bus_addr,
    input  logic [7:0]     bus_data,
    input  logic           bus_rnw,
    input  logic [SAW-1:0] rd_addr,
    output logic [7:0]     rd_data,
    output logic           mode_graphics,
    output logic           mode_mixed,
    output logic           mode_page2,
    output logic           mode_hires
);
    logic           fall;
    logic [15:0]    lat_addr;
    logic [7:0]     lat_data;
    cap_state_e     cap_state;
    logic           wr_en, sw_en;
    logic           shadow_hit, switch_hit, switch_val;
    logic [SAW-1:0] shadow_idx;
    logic [1:0]     switch_sel;
    vmode_t         mode_q;

    vsh_edge_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (bus_phi2),
        .fall     (fall)
    );

    vsh_capture_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .fall       (fall),
        .bus_addr   (bus_addr),
        .bus_data   (bus_data),
        .bus_rnw    (bus_rnw),
        .shadow_hit (shadow_hit),
        .switch_hit (switch_hit),
        .lat_addr   (lat_addr),
        .lat_data   (lat_data),
        .state      (cap_state),
        .wr_en      (wr_en),
        .sw_en      (sw_en)
    );

    vsh_decode #(.TXT_AW(TXT_AW), .HGR_AW(HGR_AW), .SAW(SAW)) u_dec (
        .addr       (lat_addr),
        .shadow_hit (shadow_hit),
        .shadow_idx (shadow_idx),
        .switch_hit (switch_hit),
        .switch_sel (switch_sel),
        .switch_val (switch_val)
    );

    vsh_shadow_mem #(.DEPTH(DEPTH), .LANES(LANES), .SAW(SAW)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (shadow_idx),
        .wr_data (lat_data),
        .rd_idx  (rd_addr),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RESET;
        end else if (sw_en) begin
            unique case (switch_sel)
                2'd0: mode_q.graphics <= switch_val;
                2'd1: mode_q.mixed    <= switch_val;
                2'd2: mode_q.page2    <= switch_val;
                2'd3: mode_q.hires    <= switch_val;
                default: mode_q <= mode_q;
            endcase
        end
    end

    assign mode_graphics = mode_q.graphics;
    assign mode_mixed    = mode_q.mixed;
    assign mode_page2    = mode_q.page2;
    assign mode_hires    = mode_q.hires;
endmodule

// File: rtl/vsh_checker.sv
module vsh_checker
    import vshadow_pkg::*;
#(
    parameter int DEPTH = 18432,
    parameter int SAW   = 15
) (
    input logic           clk,
    input logic           rst,
    input logic           fall,
    input cap_state_e     st,
    input logic           wr_en,
    input logic           sw_en,
    input logic [SAW-1:0] wr_idx,
    input logic [3:0]     mode
);
    // R13: every detected phase-2 fall finds the machine ready
    assert_ready_on_edge_R13: assert property (@(posedge clk) disable iff (rst)
        fall |-> st == ST_IDLE);

    // R5: at most one commit per bus cycle
    assert_single_commit_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R4: commits never leave the 18 KB map
    assert_idx_in_map_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> 32'(wr_idx) < DEPTH);

    // R11: flags move only on a switch strobe
    assert_mode_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !sw_en |=> $stable(mode));

    // R12: flags are cleared right after reset
    assert_reset_mode_R12: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> mode == 4'b0000);
endmodule

bind vsh_video_shadow vsh_checker #(.DEPTH(DEPTH), .SAW(SAW)) chk_i (
    .clk    (clk),
    .rst    (rst),
    .fall   (fall),
    .st     (cap_state),
    .wr_en  (wr_en),
    .sw_en  (sw_en),
    .wr_idx (shadow_idx),
    .mode   ({mode_graphics, mode_mixed, mode_page2, mode_hires})
);

// File: tb/vsh_video_shadow_tb_top.sv
module vsh_video_shadow_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_phi2 = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic        bus_rnw = 1'b1;
    logic [14:0] rd_addr = '0;
    logic [7:0]  rd_data;
    logic        mode_graphics, mode_mixed, mode_page2, mode_hires;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vsh_video_shadow dut_i (
        .clk           (clk),
        .rst           (rst),
        .bus_phi2      (bus_phi2),
        .bus_addr      (bus_addr),
        .bus_data      (bus_data),
        .bus_rnw       (bus_rnw),
        .rd_addr       (rd_addr),
        .rd_data       (rd_data),
        .mode_graphics (mode_graphics),
        .mode_mixed    (mode_mixed),
        .mode_page2    (mode_page2),
        .mode_hires    (mode_hires)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d, input logic rnw,
                             input int hi, input int lo);
        @(negedge clk);
        bus_addr = a;
        bus_data = d;
        bus_rnw  = rnw;
        bus_phi2 = 1'b1;
        repeat (hi) @(negedge clk);
        bus_phi2 = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic host_wr(input logic [15:0] a, input logic [7:0] d);
        bus_cycle(a, d, 1'b0, 5, 6);
    endtask

    task automatic host_rd(input logic [15:0] a);
        bus_cycle(a, 8'h5A, 1'b1, 5, 6);
    endtask

    task automatic read_shadow(input logic [14:0] idx, output logic [7:0] d);
        @(negedge clk);
        rd_addr = idx;
        @(negedge clk);
        d = rd_data;
    endtask

    task automatic expect_byte(input logic [14:0] idx, input logic [7:0] exp, input string req);
        logic [7:0] d;
        read_shadow(idx, d);
        check(d === exp, req, int'(d), int'(exp));
    endtask

    function automatic int modes();
        return {28'd0, mode_graphics, mode_mixed, mode_page2, mode_hires};
    endfunction

    task automatic expect_modes(input int exp, input string req);
        @(negedge clk);
        check(modes() == exp, req, modes(), exp);
    endtask

    task automatic t_reset();
        expect_modes(0, "R12");
    endtask

    task automatic t_text_pages();
        host_wr(16'h0400, 8'hA1);
        host_wr(16'h07FF, 8'hA2);
        host_wr(16'h0800, 8'hA3);
        host_wr(16'h0BFF, 8'hA4);
        expect_byte(15'h0000, 8'hA1, "R1");
        expect_byte(15'h03FF, 8'hA2, "R1");
        expect_byte(15'h0400, 8'hA3, "R2");
        expect_byte(15'h07FF, 8'hA4, "R2");
    endtask

    task automatic t_hires_pages();
        host_wr(16'h2000, 8'hB1);
        host_wr(16'h3FFF, 8'hB2);
        host_wr(16'h4000, 8'hB3);
        host_wr(16'h5FFF, 8'hB4);
        expect_byte(15'h0800, 8'hB1, "R3");
        expect_byte(15'h27FF, 8'hB2, "R3");
        expect_byte(15'h2800, 8'hB3, "R4");
        expect_byte(15'h47FF, 8'hB4, "R4");
    endtask

    task automatic t_read_ignored();
        bus_cycle(16'h0400, 8'h55, 1'b1, 5, 6);
        bus_cycle(16'h5FFF, 8'h55, 1'b1, 5, 6);
        expect_byte(15'h0000, 8'hA1, "R5");
        expect_byte(15'h47FF, 8'hB4, "R5");
    endtask

    task automatic t_outside_ignored();
        host_wr(16'h03FF, 8'hEE);
        host_wr(16'h0C00, 8'hEE);
        host_wr(16'h1FFF, 8'hEE);
        host_wr(16'h6000, 8'hEE);
        host_wr(16'hC04F, 8'hEE);
        host_wr(16'hC058, 8'hEE);
        expect_byte(15'h0000, 8'hA1, "R6");
        expect_byte(15'h07FF, 8'hA4, "R6");
        expect_byte(15'h0800, 8'hB1, "R6");
        expect_byte(15'h47FF, 8'hB4, "R6");
        expect_modes(0, "R6");
    endtask

    task automatic t_switches();
        host_wr(16'hC050, 8'h00); expect_modes(4'b1000, "R7");
        host_wr(16'hC052, 8'h00); expect_modes(4'b1100, "R8");
        host_wr(16'hC055, 8'h00); expect_modes(4'b1110, "R9");
        host_wr(16'hC057, 8'h00); expect_modes(4'b1111, "R10");
        host_wr(16'hC051, 8'hFF); expect_modes(4'b0111, "R7");
        host_wr(16'hC053, 8'hFF); expect_modes(4'b0011, "R8");
        host_wr(16'hC054, 8'hFF); expect_modes(4'b0001, "R9");
        host_wr(16'hC056, 8'hFF); expect_modes(4'b0000, "R10");
    endtask

    task automatic t_switch_on_read();
        host_rd(16'hC050);
        host_rd(16'hC055);
        expect_modes(4'b1010, "R11");
        host_rd(16'hC051);
        host_rd(16'hC054);
        expect_modes(4'b0000, "R11");
    endtask

    task automatic t_burst();
        int bad = 0;
        for (int i = 0; i < 16; i++) begin
            bus_cycle(16'h2100 + 16'(i), 8'(i * 7 + 3), 1'b0, 4, 6);
        end
        repeat (4) @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            logic [7:0] d;
            read_shadow(15'h0900 + 15'(i), d);
            if (d !== 8'(i * 7 + 3)) begin
                bad++;
                check(1'b0, "R13", int'(d), i * 7 + 3);
            end
        end
        check(bad == 0, "R13", bad, 0);
    endtask

    task automatic t_collision();
        int bad = 0;
        host_wr(16'h0410, 8'h11);
        expect_byte(15'h0010, 8'h11, "R14");
        @(negedge clk);
        rd_addr  = 15'h0010;
        bus_addr = 16'h0410;
        bus_data = 8'h22;
        bus_rnw  = 1'b0;
        bus_phi2 = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (rd_data !== 8'h11 && rd_data !== 8'h22) bad++;
        end
        bus_phi2 = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (rd_data !== 8'h11 && rd_data !== 8'h22) bad++;
        end
        check(bad == 0, "R14", bad, 0);
        check(rd_data === 8'h22, "R14", int'(rd_data), 8'h22);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_text_pages();
        t_hires_pages();
        t_read_ignored();
        t_outside_ignored();
        t_switches();
        t_switch_on_read();
        t_burst();
        t_collision();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            finish_run();
        end
    end
endmodule